// File: doc/BRIEF.md
# E3 Transmit Overhead Insertion Port

This block sits beside an E3 transmit framer and lets external terminal equipment replace single overhead bits of each outbound frame. The framer signals every overhead bit slot on `slot_in` and flags the first slot of a frame on `sof_in`. For each slot the block raises a one-cycle strobe toward the equipment. The strobe is `oh_clk` when the port runs with its own overhead clock, or `oh_en` when the equipment uses the main transmit clock. `oh_frame` rises alongside the strobe of position 0.

The equipment counts strobes from the marker to reach the bit it wants. During that strobe cycle it drives `ext_ins` and `ext_data`. Both are captured on the edge that ends the strobe, which is the falling edge of `oh_clk`. For that slot the captured value takes the place of the configured overhead bit held in `cfg_oh`. One example is sending a remote yellow alarm by forcing the FERF bit, position 32, the first bit of the maintenance byte.

A frame has 56 overhead bits: seven bytes, most significant bit first. The outbound bit, its position and a valid flag appear one cycle after the capture edge.

Top module: `e3_oh_insert`

## Requirements
- R1: A synchronous active-high `rst` drives every output low, clears the position counter, drops any captured override and forgets frame alignment.
- R2: Until a slot arrives with `sof_in` high after reset, slots are ignored: no strobe, no marker and no `tx_oh_valid`.
- R3: `oh_frame` is high exactly in the strobe cycle of position 0, one cycle after the slot that starts the frame.
- R4: Positions count 0 to 55 with one step per slot and wrap from 55 to 0. A slot with `sof_in` high forces position 0 at any point in the frame.
- R5: With `sep_clk_mode`=1, each accepted slot gives `oh_clk` high for exactly the one cycle after `slot_in`, and `oh_en` stays low. In this mode slots are at least two cycles apart.
- R6: With `sep_clk_mode`=0, each accepted slot gives `oh_en` high for the one cycle after `slot_in`, and `oh_clk` stays low.
- R7: `ext_ins` and `ext_data` are captured on the clock edge that ends the strobe cycle. `tx_oh_bit`, `tx_oh_pos` and `tx_oh_valid` are valid in the cycle after that edge.
- R8: If `ext_ins` is 1 at capture, `tx_oh_bit` equals `ext_data`. If it is 0, `tx_oh_bit` equals `cfg_oh[55-pos]`, so position 0 uses bit 55 and the FERF bit at position 32 uses bit 23.
- R9: `ext_ins` and `ext_data` driven outside a strobe cycle have no effect. They produce no `tx_oh_valid`, and the next slot uses `cfg_oh`.
- R10: In cycles without an overhead slot (payload bits), `oh_clk` and `oh_en` both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| sep_clk_mode | input | 1 | 1 = separate overhead clock strobe, 0 = enable strobe on main clock |
| slot_in | input | 1 | Framer: current cycle is an overhead bit slot |
| sof_in | input | 1 | Framer: this slot is the first overhead bit of a frame |
| cfg_oh | input | 56 | Configured overhead bits, position 0 at bit 55 |
| ext_ins | input | 1 | External insert enable |
| ext_data | input | 1 | External overhead bit value |
| oh_clk | output | 1 | Overhead bit clock toward the equipment |
| oh_en | output | 1 | Overhead enable strobe toward the equipment |
| oh_frame | output | 1 | Frame marker, high with the position-0 strobe |
| tx_oh_bit | output | 1 | Overhead bit sent to the outbound frame |
| tx_oh_valid | output | 1 | `tx_oh_bit` is valid |
| tx_oh_pos | output | 6 | Position of `tx_oh_bit` within the frame |

## Verification
A wrong position count shows at `oh_frame` on the next position-0 strobe. It also shows within one cycle on `tx_oh_pos`, and `tx_oh_bit` then reads the wrong configured bit. A capture on the wrong edge, or a wrong alignment flag, shows up one cycle after the slot as a missing strobe or a stray `tx_oh_valid`. The scoreboard stamps each expected bit with its due cycle, so late, early or missing outputs are caught as well as wrong values.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
  localparam int OH_BITS_DEF = 56;

  typedef enum logic {
    MODE_STROBE = 1'b0,
    MODE_OHCLK  = 1'b1
  } oh_mode_e;
endpackage

// File: rtl/e3oh_pos_ctr.sv
module e3oh_pos_ctr #(
  parameter int OH_BITS = 56,
  parameter int POS_W   = $clog2(OH_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_in,
  input  logic             sof_in,
  output logic             take_o,
  output logic             first_nxt_o,
  output logic [POS_W-1:0] pos_o,
  output logic             valid_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(OH_BITS - 1);

  logic             synced_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic             valid_q;

  always_comb begin
    take_o = slot_in & (sof_in | synced_q);
    if (sof_in)             pos_nxt = '0;
    else if (pos_q == LAST) pos_nxt = '0;
    else                    pos_nxt = pos_q + 1'b1;
    first_nxt_o = take_o & (pos_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q <= 1'b0;
      pos_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= take_o;
      if (slot_in && sof_in) synced_q <= 1'b1;
      if (take_o) pos_q <= pos_nxt;
    end
  end

  assign pos_o   = pos_q;
  assign valid_o = valid_q;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (pos_q <= LAST)); // R4
  AST_SOF_POS0: assert property (@(posedge clk) disable iff (rst)
    (slot_in && sof_in) |=> (valid_q && pos_q == '0)); // R4
  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_in && !sof_in && synced_q) |=>
      (pos_q == (($past(pos_q) == LAST) ? '0 : $past(pos_q) + 1'b1))); // R4
  AST_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!synced_q && !(slot_in && sof_in)) |=> !valid_q); // R2
endmodule

// File: rtl/e3oh_strobe.sv
module e3oh_strobe (
  input  logic                clk,
  input  logic                rst,
  input  e3oh_pkg::oh_mode_e  mode,
  input  logic                take,
  input  logic                first_nxt,
  output logic                oh_clk,
  output logic                oh_en,
  output logic                oh_frame
);
  import e3oh_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_clk   <= 1'b0;
      oh_en    <= 1'b0;
      oh_frame <= 1'b0;
    end else begin
      oh_clk   <= take & (mode == MODE_OHCLK);
      oh_en    <= take & (mode == MODE_STROBE);
      oh_frame <= first_nxt;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({oh_clk, oh_en})); // R5
  AST_FRAME_STROBE: assert property (@(posedge clk) disable iff (rst)
    oh_frame |-> (oh_clk || oh_en)); // R3
  AST_IDLE_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    !take |=> (!oh_clk && !oh_en)); // R10
endmodule

// File: rtl/e3oh_ins_mux.sv
module e3oh_ins_mux #(
  parameter int OH_BITS = 56,
  parameter int POS_W   = $clog2(OH_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_valid,
  input  logic [POS_W-1:0]   s1_pos,
  input  logic [OH_BITS-1:0] cfg_oh,
  input  logic               ext_ins,
  input  logic               ext_data,
  output logic               tx_bit,
  output logic               tx_valid,
  output logic [POS_W-1:0]   tx_pos
);
  localparam logic [POS_W-1:0] TOP_IDX = POS_W'(OH_BITS - 1);

  logic [POS_W-1:0] idx;
  logic             int_bit;

  always_comb begin
    idx     = TOP_IDX - s1_pos;
    int_bit = cfg_oh[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_pos   <= '0;
    end else begin
      tx_valid <= s1_valid;
      if (s1_valid) begin
        tx_bit <= ext_ins ? ext_data : int_bit;
        tx_pos <= s1_pos;
      end else begin
        tx_bit <= 1'b0;
      end
    end
  end

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !tx_valid); // R9
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && ext_ins) |=> (tx_bit == $past(ext_data))); // R8
  AST_CAPTURE_NEXT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (tx_valid && tx_pos == $past(s1_pos))); // R7
endmodule

// File: rtl/e3_oh_insert.sv
module e3_oh_insert #(
  parameter int OH_BITS = e3oh_pkg::OH_BITS_DEF,
  parameter int POS_W   = $clog2(OH_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sep_clk_mode,
  input  logic               slot_in,
  input  logic               sof_in,
  input  logic [OH_BITS-1:0] cfg_oh,
  input  logic               ext_ins,
  input  logic               ext_data,
  output logic               oh_clk,
  output logic               oh_en,
  output logic               oh_frame,
  output logic               tx_oh_bit,
  output logic               tx_oh_valid,
  output logic [POS_W-1:0]   tx_oh_pos
);
  import e3oh_pkg::*;

  logic             take;
  logic             first_nxt;
  logic [POS_W-1:0] s1_pos;
  logic             s1_valid;
  oh_mode_e         mode;

  assign mode = sep_clk_mode ? MODE_OHCLK : MODE_STROBE;

  e3oh_pos_ctr #(.OH_BITS(OH_BITS), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .slot_in(slot_in), .sof_in(sof_in),
    .take_o(take), .first_nxt_o(first_nxt), .pos_o(s1_pos), .valid_o(s1_valid)
  );

  e3oh_strobe u_strobe (
    .clk(clk), .rst(rst), .mode(mode), .take(take), .first_nxt(first_nxt),
    .oh_clk(oh_clk), .oh_en(oh_en), .oh_frame(oh_frame)
  );

  e3oh_ins_mux #(.OH_BITS(OH_BITS), .POS_W(POS_W)) u_mux (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_pos(s1_pos),
    .cfg_oh(cfg_oh), .ext_ins(ext_ins), .ext_data(ext_data),
    .tx_bit(tx_oh_bit), .tx_valid(tx_oh_valid), .tx_pos(tx_oh_pos)
  );

  AST_FRAME_POS0: assert property (@(posedge clk) disable iff (rst)
    oh_frame |-> (s1_valid && s1_pos == '0)); // R3
  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (rst)
    (oh_clk || oh_en) |-> s1_valid); // R6
endmodule

// File: tb/e3_oh_insert_tb.sv
`timescale 1ns/1ps
module e3_oh_insert_tb;
  localparam int NB = 56;
  localparam logic [NB-1:0] CFG = 56'h9BC427E1583DA6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sep_clk_mode = 1'b1, slot_in = 1'b0, sof_in = 1'b0;
  logic ext_ins = 1'b0, ext_data = 1'b0;
  logic oh_clk, oh_en, oh_frame, tx_oh_bit, tx_oh_valid;
  logic [5:0] tx_oh_pos;

  always #2 clk = ~clk;

  e3_oh_insert u_dut (
    .clk(clk), .rst(rst), .sep_clk_mode(sep_clk_mode), .slot_in(slot_in),
    .sof_in(sof_in), .cfg_oh(CFG), .ext_ins(ext_ins), .ext_data(ext_data),
    .oh_clk(oh_clk), .oh_en(oh_en), .oh_frame(oh_frame), .tx_oh_bit(tx_oh_bit),
    .tx_oh_valid(tx_oh_valid), .tx_oh_pos(tx_oh_pos)
  );

  typedef struct { int pos; bit val; int due; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_sync = 0;
  int m_pos = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver: one slot, strobe checks, override drive, expected item pushed
  task automatic do_slot(input bit sof, input bit ins, input bit dat, input bit sep);
    bit take;
    exp_t e;
    @(negedge clk);
    ext_ins = 0; sep_clk_mode = sep; slot_in = 1; sof_in = sof;
    take = m_sync || sof;
    if (sof) m_sync = 1;
    @(negedge clk);
    slot_in = 0; sof_in = 0;
    if (take) begin
      m_pos = sof ? 0 : (m_pos + 1) % NB;
      chk(oh_clk == sep, sep ? "R5" : "R6", "oh_clk", oh_clk, sep);
      chk(oh_en == !sep, sep ? "R5" : "R6", "oh_en", oh_en, !sep);
      chk(oh_frame == (m_pos == 0), "R3", "oh_frame", oh_frame, m_pos == 0);
      ext_ins = ins; ext_data = dat;
      e.pos = m_pos; e.val = ins ? dat : CFG[NB-1-m_pos]; e.due = cyc + 1;
      sb.push_back(e);
    end else begin
      chk(!oh_clk && !oh_en && !oh_frame, "R2", "strobe before sync",
          {oh_clk, oh_en, oh_frame}, 0);
    end
  endtask

  // Insert request outside any strobe: must be ignored
  task automatic idle_ins(input bit dat);
    @(negedge clk);
    ext_ins = 1; ext_data = dat;
    @(negedge clk);
    chk(!tx_oh_valid, "R9", "valid from idle insert", tx_oh_valid, 0);
    chk(!oh_clk && !oh_en, "R10", "strobe in payload", {oh_clk, oh_en}, 0);
    ext_ins = 0;
  endtask

  // Monitor: pop expected items as outputs appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tx_oh_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R7", "unexpected tx_oh_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, "R7", "output cycle", cyc, e.due);
          chk(int'(tx_oh_pos) == e.pos, "R4", "tx_oh_pos", tx_oh_pos, e.pos);
          chk(tx_oh_bit == e.val, "R8", "tx_oh_bit", tx_oh_bit, e.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({oh_clk, oh_en, oh_frame, tx_oh_valid, tx_oh_bit} == 0, "R1",
        "outputs after reset", {oh_clk, oh_en, oh_frame, tx_oh_valid, tx_oh_bit}, 0);
    chk(tx_oh_pos == 0, "R1", "pos after reset", tx_oh_pos, 0);

    // R2: slots before any frame start are ignored
    do_slot(0, 1, 1, 1);
    do_slot(0, 0, 0, 1);
    @(negedge clk);
    chk(!tx_oh_valid, "R2", "valid before sync", tx_oh_valid, 0);

    // Separate clock mode: full frame, yellow alarm at FERF (32), override at 5
    for (int i = 0; i < NB; i++)
      do_slot(i == 0, (i == 32) || (i == 5), (i == 32) ? 1'b1 : ~CFG[NB-1-5], 1);
    // R4: wrap 55 -> 0 without sof, partial second frame
    for (int i = 0; i < 4; i++) do_slot(0, 0, 0, 1);

    // R9/R10: insert outside strobes ignored, next slot uses configured bit
    idle_ins(~CFG[NB-1-4]);
    do_slot(0, 0, 0, 1);

    // Enable strobe mode: resync mid-frame, then full frame with overrides
    do_slot(1, 0, 0, 0);
    for (int i = 1; i < NB; i++)
      do_slot(0, (i % 9) == 0, (i % 2) == 0, 0);
    do_slot(0, 1, ~CFG[NB-1], 0);
    for (int i = 0; i < 10; i++) do_slot(0, 0, 0, 0);
    do_slot(1, 0, 0, 1);   // R4: sof mid-frame forces position 0
    do_slot(0, 1, 0, 1);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7", "missing outputs", sb.size(), 0);

    // R1: reset mid-stream forgets alignment
    do_slot(0, 0, 0, 0);
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    sb.delete();
    m_sync = 0; m_pos = 0;
    chk({oh_clk, oh_en, oh_frame, tx_oh_valid} == 0, "R1", "outputs after reset 2",
        {oh_clk, oh_en, oh_frame, tx_oh_valid}, 0);
    do_slot(0, 1, 1, 0);
    @(negedge clk);
    chk(!tx_oh_valid, "R2", "valid after reset before sof", tx_oh_valid, 0);
    do_slot(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7", "missing outputs end", sb.size(), 0);
    finish_run();
  end
endmodule